// File: doc/BRIEF.md
# Pseudowire Ingress Label Stack Builder with Per-Flow Balancing Label

This block sits on the ingress side of a pseudowire forwarder. For each outgoing packet it takes one descriptor: a 32-bit flow identifier from the service classifier, a control-frame flag, the pseudowire label, up to `MAX_TUN` tunnel labels, the traffic class and TTL for the stack, a control-word enable with its word, and a balancing enable. From these it emits the MPLS header as 32-bit words, one word per accepted cycle. The payload words then pass through unchanged until the last one.

When balancing is enabled, the block inserts an extra label between the pseudowire label and the optional control word. Core routers that hash the label stack then spread the flows over equal-cost paths. The value of that label is derived from the flow identifier by a fixed mixing function, so every packet of a flow carries the same value. Control frames always get one provisioned value, so they stay on one path and arrive in order.

Top module: `pw_lb_stack_builder`

## Requirements
- R1: After a descriptor is accepted, the words leave in this order: the tunnel labels (entry 0 of `hdr_tun` first, `min(hdr_tun_cnt, MAX_TUN)` of them), then the pseudowire label, then the balancing label if enabled, then the control word if enabled, then the payload. The first header word is offered in the cycle after the descriptor handshake.
- R2: Every label word has the layout label[31:12], traffic class[11:9], bottom-of-stack bit [8], TTL[7:0], using the descriptor's `hdr_tc` and `hdr_ttl`. Tunnel labels always carry bit 8 = 0.
- R3: With `hdr_lb_en`=1, the pseudowire label has bit 8 = 0 and the balancing label has bit 8 = 1. With `hdr_lb_en`=0, no balancing word is emitted and the pseudowire label has bit 8 = 1.
- R4: With `hdr_cw_en`=1, `hdr_cw` is emitted unchanged after the labels. With `hdr_cw_en`=0, the first payload word follows the last label directly.
- R5: For a data frame, the balancing value is computed from the flow id `f` as follows: h = f ^ (f>>16); h = (h * 0x7FEB352D) mod 2^32; h = h ^ (h>>15); the value is h[31:12]. A result below 16 has bit 4 set, so that reserved labels are never produced. Equal flow ids give equal values.
- R6: For a control frame (`hdr_ctrl`=1), the balancing value is the parameter `CTRL_LABEL`, whatever the flow id.
- R7: Payload words reach `out_data` unchanged, and `out_last` follows `pl_last`. `out_last` is never set on a header word. `hdr_ready` stays low from the descriptor handshake until the handshake of the last payload word, and `out_valid` is low while `hdr_ready` is high.
- R8: While a header word is offered and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R9: After reset, `out_valid`=0 and `hdr_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Descriptor offered |
| hdr_ready | output | 1 | Block idle, descriptor taken |
| hdr_flow | input | 32 | Flow or flow-group identifier |
| hdr_ctrl | input | 1 | Packet is a control frame |
| hdr_pw | input | 20 | Pseudowire label |
| hdr_tun | input | MAX_TUN*20 | Tunnel labels, entry 0 in bits [19:0], outermost first |
| hdr_tun_cnt | input | $clog2(MAX_TUN+1) | Number of tunnel labels |
| hdr_tc | input | 3 | Traffic class for all labels |
| hdr_ttl | input | 8 | TTL for all labels |
| hdr_lb_en | input | 1 | Insert the balancing label |
| hdr_cw_en | input | 1 | Insert the control word |
| hdr_cw | input | 32 | Control word |
| pl_valid | input | 1 | Payload word offered |
| pl_ready | output | 1 | Payload word taken |
| pl_data | input | 32 | Payload word |
| pl_last | input | 1 | Last payload word |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Output word taken |
| out_data | output | 32 | Header or payload word |
| out_last | output | 1 | Last word of the packet |

## Verification
A wrong tunnel index or a wrong phase in the sequencer shows up at once as a misplaced or missing word: a word count that disagrees with the descriptor, a bottom-of-stack bit on the wrong label, or `hdr_ready` coming back too early or too late. A fault in the mixing path only appears in the balancing word. It is caught by comparing each packet with the formula, over random flows and over flow 0, which exercises the remap. Faults in hold logic appear under random back-pressure, in the first stalled cycle.

// File: rtl/pw_lb_stack_builder.sv
module pw_lb_stack_builder #(
  parameter int MAX_TUN = 4,
  parameter logic [19:0] CTRL_LABEL = 20'h0FFFF,
  localparam int CNT_W = $clog2(MAX_TUN + 1),
  localparam int IDX_W = (MAX_TUN > 1) ? $clog2(MAX_TUN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hdr_valid,
  output logic                 hdr_ready,
  input  logic [31:0]          hdr_flow,
  input  logic                 hdr_ctrl,
  input  logic [19:0]          hdr_pw,
  input  logic [MAX_TUN*20-1:0] hdr_tun,
  input  logic [CNT_W-1:0]     hdr_tun_cnt,
  input  logic [2:0]           hdr_tc,
  input  logic [7:0]           hdr_ttl,
  input  logic                 hdr_lb_en,
  input  logic                 hdr_cw_en,
  input  logic [31:0]          hdr_cw,
  input  logic                 pl_valid,
  output logic                 pl_ready,
  input  logic [31:0]          pl_data,
  input  logic                 pl_last,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [31:0]          out_data,
  output logic                 out_last
);

  typedef enum logic [2:0] {S_IDLE, S_TUN, S_PW, S_LB, S_CW, S_PAY} st_t;

  function automatic logic [19:0] mix20(input logic [31:0] f);
    logic [31:0] h;
    h = f ^ (f >> 16);
    h = h * 32'h7FEB352D;
    h = h ^ (h >> 15);
    if (h[31:16] == 16'd0) mix20 = h[31:12] | 20'h00010;
    else                   mix20 = h[31:12];
  endfunction

  st_t              st;
  logic [19:0]      tun_q [MAX_TUN];
  logic [CNT_W-1:0] ntun;
  logic [IDX_W-1:0] ti;
  logic [19:0]      pw_q, lb_q;
  logic [2:0]       tc_q;
  logic [7:0]       ttl_q;
  logic             lb_en_q, cw_en_q;
  logic [31:0]      cw_q;
  logic             in_hdr, take_hdr, step;
  logic [CNT_W-1:0] ntun_in;
  logic [19:0]      tun_sel;

  assign ntun_in  = (hdr_tun_cnt > CNT_W'(MAX_TUN)) ? CNT_W'(MAX_TUN) : hdr_tun_cnt;
  assign hdr_ready = (st == S_IDLE);
  assign take_hdr = hdr_valid && hdr_ready;
  assign in_hdr   = (st == S_TUN) || (st == S_PW) || (st == S_LB) || (st == S_CW);
  assign step     = in_hdr && out_ready;
  assign tun_sel  = tun_q[ti];

  assign out_valid = in_hdr || ((st == S_PAY) && pl_valid);
  assign pl_ready  = (st == S_PAY) && out_ready;
  assign out_last  = (st == S_PAY) && pl_last;

  always_comb begin
    case (st)
      S_TUN:   out_data = {tun_sel, tc_q, 1'b0, ttl_q};
      S_PW:    out_data = {pw_q, tc_q, ~lb_en_q, ttl_q};
      S_LB:    out_data = {lb_q, tc_q, 1'b1, ttl_q};
      S_CW:    out_data = cw_q;
      S_PAY:   out_data = pl_data;
      default: out_data = 32'd0;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < MAX_TUN; g++) begin : g_tun
      always_ff @(posedge clk) begin
        if (!rst_n) tun_q[g] <= 20'd0;
        else if (take_hdr) tun_q[g] <= hdr_tun[g*20 +: 20];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ntun <= '0; pw_q <= '0; lb_q <= '0; tc_q <= '0; ttl_q <= '0;
      lb_en_q <= 1'b0; cw_en_q <= 1'b0; cw_q <= '0;
    end else if (take_hdr) begin
      ntun    <= ntun_in;
      pw_q    <= hdr_pw;
      lb_q    <= hdr_ctrl ? CTRL_LABEL : mix20(hdr_flow);
      tc_q    <= hdr_tc;
      ttl_q   <= hdr_ttl;
      lb_en_q <= hdr_lb_en;
      cw_en_q <= hdr_cw_en;
      cw_q    <= hdr_cw;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ti <= '0;
    end else begin
      case (st)
        S_IDLE: if (take_hdr) begin
          ti <= '0;
          st <= (ntun_in != '0) ? S_TUN : S_PW;
        end
        S_TUN: if (step) begin
          if (CNT_W'(ti) + CNT_W'(1) == ntun) st <= S_PW;
          else ti <= ti + IDX_W'(1);
        end
        S_PW: if (step) st <= lb_en_q ? S_LB : (cw_en_q ? S_CW : S_PAY);
        S_LB: if (step) st <= cw_en_q ? S_CW : S_PAY;
        S_CW: if (step) st <= S_PAY;
        S_PAY: if (pl_valid && out_ready && pl_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pw_lb_stack_chk.sv
module pw_lb_stack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hdr_valid,
  input logic        hdr_ready,
  input logic        in_hdr,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_last
);
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    in_hdr && out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ready |-> !out_valid); // R7
  AST_HDR_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    in_hdr |-> !out_last); // R7
  AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready |=> in_hdr && out_valid && !hdr_ready); // R1
endmodule

bind pw_lb_stack_builder pw_lb_stack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .in_hdr(in_hdr), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last)
);

// File: tb/sim_pw_lb_stack_builder.sv
module sim_pw_lb_stack_builder;
  localparam int MAX_TUN = 4;
  localparam int CNT_W = $clog2(MAX_TUN + 1);
  localparam logic [19:0] CTRL_LABEL = 20'h0FFFF;

  logic clk = 0, rst_n = 0;
  logic hdr_valid = 0, hdr_ctrl = 0, hdr_lb_en = 0, hdr_cw_en = 0;
  logic hdr_ready;
  logic [31:0] hdr_flow = 0, hdr_cw = 0;
  logic [19:0] hdr_pw = 0;
  logic [MAX_TUN*20-1:0] hdr_tun = 0;
  logic [CNT_W-1:0] hdr_tun_cnt = 0;
  logic [2:0] hdr_tc = 0;
  logic [7:0] hdr_ttl = 0;
  logic pl_valid = 0, pl_last = 0, pl_ready;
  logic [31:0] pl_data = 0;
  logic out_valid, out_last, out_ready = 0;
  logic [31:0] out_data;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pw_lb_stack_builder #(.MAX_TUN(MAX_TUN), .CTRL_LABEL(CTRL_LABEL)) u0 (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_flow(hdr_flow), .hdr_ctrl(hdr_ctrl), .hdr_pw(hdr_pw), .hdr_tun(hdr_tun),
    .hdr_tun_cnt(hdr_tun_cnt), .hdr_tc(hdr_tc), .hdr_ttl(hdr_ttl),
    .hdr_lb_en(hdr_lb_en), .hdr_cw_en(hdr_cw_en), .hdr_cw(hdr_cw),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data), .pl_last(pl_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  function automatic logic [19:0] exp_lb(input logic [31:0] f);
    logic [31:0] h;
    logic [19:0] v;
    h = f ^ (f >> 16);
    h = h * 32'h7FEB352D;
    h = h ^ (h >> 15);
    v = h[31:12];
    if (v < 20'd16) v = v | 20'd16;
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_pkt(input logic [31:0] flow, input bit ctrl, input int nt,
                         input bit lbe, input bit cwe, input int plen, input bit rnd);
    logic [32:0] exp_w [24];
    string tag [24];
    logic [31:0] pay [8];
    int nh, ntot, k, pi, guard;
    int ntu;
    logic [2:0] tc;
    logic [7:0] ttl;
    logic [19:0] lbv;
    bit prev_hold;
    logic [31:0] prev_d;
    tc = 3'($urandom); ttl = 8'($urandom);
    hdr_flow = flow; hdr_ctrl = ctrl; hdr_lb_en = lbe; hdr_cw_en = cwe;
    hdr_pw = 20'($urandom); hdr_cw = $urandom; hdr_tc = tc; hdr_ttl = ttl;
    for (int i = 0; i < MAX_TUN; i++) hdr_tun[i*20 +: 20] = 20'($urandom);
    hdr_tun_cnt = CNT_W'(nt);
    ntu = (nt > MAX_TUN) ? MAX_TUN : nt;
    nh = 0;
    for (int i = 0; i < ntu; i++) begin
      exp_w[nh] = {1'b0, hdr_tun[i*20 +: 20], tc, 1'b0, ttl}; tag[nh] = "R1 R2 tunnel"; nh++;
    end
    exp_w[nh] = {1'b0, hdr_pw, tc, ~lbe, ttl}; tag[nh] = "R3 pw label"; nh++;
    if (lbe) begin
      lbv = ctrl ? CTRL_LABEL : exp_lb(flow);
      exp_w[nh] = {1'b0, lbv, tc, 1'b1, ttl};
      tag[nh] = ctrl ? "R6 ctrl label" : "R5 lb label"; nh++;
    end
    if (cwe) begin exp_w[nh] = {1'b0, hdr_cw}; tag[nh] = "R4 control word"; nh++; end
    ntot = nh;
    for (int i = 0; i < plen; i++) begin
      pay[i] = $urandom;
      exp_w[ntot] = {(i == plen - 1), pay[i]}; tag[ntot] = "R7 payload"; ntot++;
    end
    @(negedge clk);
    hdr_valid = 1;
    #1;
    check("R7 idle ready", 64'(hdr_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    hdr_valid = 0;
    #1;
    check("R7 busy", 64'(hdr_ready), 64'd0);
    k = 0; pi = 0; guard = 0; prev_hold = 0; prev_d = 0;
    while (k < ntot && guard < 400) begin
      out_ready = rnd ? 1'($urandom_range(0, 2) != 0) : 1'b1;
      pl_valid  = (pi < plen) && (rnd ? 1'($urandom_range(0, 3) != 0) : 1'b1);
      pl_data   = (pi < plen) ? pay[pi] : 32'd0;
      pl_last   = (pi == plen - 1);
      #1;
      if (prev_hold) begin
        check("R8 hold valid", 64'(out_valid), 64'd1);
        check("R8 hold data", 64'(out_data), 64'(prev_d));
      end
      prev_hold = (k < nh) && out_valid && !out_ready;
      prev_d = out_data;
      if (out_valid && out_ready) begin
        check(tag[k], {31'd0, out_last, out_data}, 64'(exp_w[k]));
        k++;
      end
      if (pl_valid && pl_ready) pi++;
      guard++;
      @(negedge clk);
    end
    out_ready = 0; pl_valid = 0; pl_last = 0;
    #1;
    check("R1 word count", 64'(k), 64'(ntot));
    check("R7 ready after last", 64'(hdr_ready), 64'd1);
    check("R7 idle no output", 64'(out_valid), 64'd0);
  endtask

  task automatic run_all;
    logic [19:0] a, b;
    repeat (3) @(negedge clk);
    #1;
    check("R9 reset out_valid", 64'(out_valid), 64'd0);
    check("R9 reset hdr_ready", 64'(hdr_ready), 64'd1);
    rst_n = 1;
    run_pkt(32'h1234_5678, 0, 2, 1, 1, 3, 0);
    run_pkt(32'hDEAD_BEEF, 0, 0, 1, 0, 1, 0);
    run_pkt(32'h0000_0000, 0, 1, 1, 1, 2, 0);
    run_pkt(32'hCAFE_0001, 1, 3, 1, 0, 2, 0);
    run_pkt(32'h0BAD_F00D, 0, 2, 0, 1, 2, 0);
    run_pkt(32'h0BAD_F00D, 0, 0, 0, 0, 1, 0);
    run_pkt(32'h7777_0000, 0, 6, 1, 1, 2, 1);
    run_pkt(32'h1234_5678, 0, MAX_TUN, 1, 0, 4, 1);
    a = exp_lb(32'h55AA_1234); b = exp_lb(32'h55AA_1234);
    check("R5 stable per flow", 64'(a), 64'(b));
    for (int n = 0; n < 60; n++)
      run_pkt($urandom, 1'($urandom_range(0, 4) == 0), $urandom_range(0, MAX_TUN + 1),
              1'($urandom), 1'($urandom), $urandom_range(1, 8), 1'($urandom));
  endtask

  initial begin
    process::self().srandom(32'd20240613);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule